// File: doc/BRIEF.md
# Hierarchical Thermometer-to-Binary Encoder

This block turns a wide thermometer snapshot, such as the latched tap states of a delay line in a time-to-digital converter, into a compact binary fine-time code. The code is the bit index of the lowest zero in the snapshot. For a clean thermometer of k ones followed by zeros, that index equals k.

The search runs as a tree of 8-way splits. The first level picks which of eight 64-bit slices holds the lowest zero and passes that slice on. The second level does the same over eight 8-bit pieces. The last level picks one bit out of eight. Each level contributes three bits to the code, the first level most significant, and each level ends in a register.

A snapshot whose bits are all zero raises an empty flag and yields code 0. A snapshot with no zero at all raises a full flag and yields the highest code. Bubble cleanup and linearity calibration happen outside this block.

Top module: `t2b_encoder`

## Requirements
- R1: For a clean thermometer input with k low-order ones and all other bits zero, where 1 <= k <= 511, out_code equals k.
- R2: An input sampled on a rising clock edge produces its result on the outputs just after the third rising edge, counting the sampling edge as the first. out_valid repeats in_valid with the same delay.
- R3: An all-ones input gives out_full = 1, out_empty = 0 and out_code = 511.
- R4: An all-zeros input gives out_empty = 1, out_full = 0 and out_code = 0.
- R5: An input holding at least one 0 and at least one 1 gives out_empty = 0 and out_full = 0.
- R6: The block accepts a new input on every cycle. An idle cycle (in_valid = 0) yields out_valid = 0 in its own result slot and leaves the results before and after it unchanged.
- R7: While rst_n is low, and after release until a valid input has passed through, out_valid is 0.
- R8: For any input that holds a zero, out_code is the index of its lowest zero bit, whatever the bits above that index. Bits [8:6] of the code name the 64-bit slice, bits [5:3] name the 8-bit piece within that slice, and bits [2:0] name the bit within that piece.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks in_therm as a snapshot to encode |
| in_therm | input | 512 | Thermometer snapshot; bit 0 is the start of the line |
| out_valid | output | 1 | Marks the outputs as one encoded result |
| out_code | output | 9 | Index of the lowest zero bit |
| out_empty | output | 1 | The snapshot was all zeros |
| out_full | output | 1 | The snapshot held no zero |

## Verification
The valid-tracking assertions assume that in_valid is driven to a known level from the first clock edge. They only compare it with the pipeline one edge after reset has been released. The bench therefore drives in_valid low from time zero, holds it low through reset, and changes inputs only on falling edges.

The flag and code assertions rely on nothing about the data: they hold for clean, bubbled and random snapshots alike. For that reason the stimulus mixes a full sweep of clean thermometers with random vectors whose lowest zero is placed at a random position.

// File: rtl/t2b_pkg.sv
package t2b_pkg;
  localparam int WAY_LG = 3;
  localparam int WAYS   = 1 << WAY_LG;

  // lowest set bit of a per-way "holds a zero" mask; last way when none is set
  function automatic logic [WAY_LG-1:0] lowest_set(input logic [WAYS-1:0] m);
    logic [WAY_LG-1:0] r;
    r = WAY_LG'(WAYS - 1);
    for (int i = WAYS - 1; i >= 0; i--)
      if (m[i]) r = WAY_LG'(i);
    return r;
  endfunction
endpackage

// File: rtl/t2b_split_stage.sv
module t2b_split_stage
  import t2b_pkg::*;
#(
  parameter int IN_W   = 512,
  parameter int CODE_W = 9,
  parameter int SHIFT  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   v_i,
  input  logic [IN_W-1:0]        slc_i,
  input  logic [CODE_W-1:0]      code_i,
  input  logic                   empty_i,
  input  logic                   full_i,
  output logic                   v_o,
  output logic [IN_W/WAYS-1:0]   slc_o,
  output logic [CODE_W-1:0]      code_o,
  output logic                   empty_o,
  output logic                   full_o
);
  localparam int GW = IN_W / WAYS;

  logic [WAYS-1:0]   zmask;
  logic [WAY_LG-1:0] way;
  logic [GW-1:0]     picked;
  logic [CODE_W-1:0] code_nx;

  always_comb begin
    for (int g = 0; g < WAYS; g++)
      zmask[g] = ~&slc_i[g*GW +: GW];
    way     = lowest_set(zmask);
    picked  = slc_i[way*GW +: GW];
    code_nx = code_i | (CODE_W'(way) << SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o     <= 1'b0;
      slc_o   <= '0;
      code_o  <= '0;
      empty_o <= 1'b0;
      full_o  <= 1'b0;
    end else begin
      v_o     <= v_i;
      slc_o   <= picked;
      code_o  <= code_nx;
      empty_o <= empty_i;
      full_o  <= full_i;
    end
  end
endmodule

// File: rtl/t2b_encoder.sv
module t2b_encoder
  import t2b_pkg::*;
#(
  parameter int LEVELS = 3,
  localparam int IN_W   = 1 << (WAY_LG * LEVELS),
  localparam int CODE_W = WAY_LG * LEVELS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_therm,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic              out_empty,
  output logic              out_full
);
  // per-level valid, brought out for the checker
  logic [LEVELS-1:0] stage_vld;

  for (genvar l = 0; l < LEVELS; l++) begin : lvl
    localparam int SW    = IN_W >> (WAY_LG * l);
    localparam int SHIFT = CODE_W - WAY_LG * (l + 1);
    logic              v_i, v_o, e_i, e_o, f_i, f_o;
    logic [SW-1:0]     s_i;
    logic [SW/WAYS-1:0] s_o;
    logic [CODE_W-1:0] c_i, c_o;

    if (l == 0) begin : head
      assign v_i = in_valid;
      assign s_i = in_therm;
      assign c_i = '0;
      assign e_i = ~|in_therm;
      assign f_i = &in_therm;
    end else begin : link
      assign v_i = lvl[l-1].v_o;
      assign s_i = lvl[l-1].s_o;
      assign c_i = lvl[l-1].c_o;
      assign e_i = lvl[l-1].e_o;
      assign f_i = lvl[l-1].f_o;
    end

    t2b_split_stage #(.IN_W(SW), .CODE_W(CODE_W), .SHIFT(SHIFT)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .v_i(v_i), .slc_i(s_i), .code_i(c_i), .empty_i(e_i), .full_i(f_i),
      .v_o(v_o), .slc_o(s_o), .code_o(c_o), .empty_o(e_o), .full_o(f_o)
    );

    assign stage_vld[l] = v_o;
  end

  assign out_valid = lvl[LEVELS-1].v_o;
  assign out_code  = lvl[LEVELS-1].c_o;
  assign out_empty = lvl[LEVELS-1].e_o;
  assign out_full  = lvl[LEVELS-1].f_o;
endmodule

// File: rtl/t2b_encoder_chk.sv
module t2b_encoder_chk #(
  parameter int LEVELS = 3,
  parameter int CODE_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [LEVELS-1:0] stage_vld,
  input logic              out_valid,
  input logic [CODE_W-1:0] out_code,
  input logic              out_empty,
  input logic              out_full
);
  logic warm;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) warm <= 1'b0;
    else        warm <= 1'b1;

  assert_full_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_full) |-> (&out_code));

  assert_empty_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_empty) |-> (out_code == '0));

  assert_flags_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_empty && out_full));

  assert_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (stage_vld[0] == $past(in_valid)));

  for (genvar i = 0; i + 1 < LEVELS; i++) begin : hop
    assert_hop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (stage_vld[i+1] == $past(stage_vld[i])));
  end

  always @(posedge clk)
    if (!rst_n) assert_reset_R7: assert (!out_valid);
endmodule

bind t2b_encoder t2b_encoder_chk #(.LEVELS(LEVELS), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .stage_vld(stage_vld),
  .out_valid(out_valid), .out_code(out_code),
  .out_empty(out_empty), .out_full(out_full)
);

// File: tb/t2b_encoder_test.sv
module t2b_encoder_test;
  localparam int N = 512;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [N-1:0] in_therm = '0;
  logic         out_valid;
  logic [8:0]   out_code;
  logic         out_empty, out_full;

  int total = 0;
  int fails = 0;
  bit done = 0;

  int q_v[$], q_c[$], q_e[$], q_f[$];

  always #2.5 clk = ~clk;

  t2b_encoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_therm(in_therm),
    .out_valid(out_valid), .out_code(out_code),
    .out_empty(out_empty), .out_full(out_full)
  );

  function automatic logic [N-1:0] therm(input int k);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (i < k);
    return v;
  endfunction

  // linear search for the lowest zero
  task automatic expect_of(input logic [N-1:0] v, output int c, output int e, output int f);
    e = (v == '0);
    f = (v == '1);
    c = 511;
    for (int i = N - 1; i >= 0; i--) if (!v[i]) c = i;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    int ev, ec, ee, ef;
    string tag;
    ev = q_v.pop_front(); ec = q_c.pop_front();
    ee = q_e.pop_front(); ef = q_f.pop_front();
    check(out_valid == ev[0], "R2/R6 valid slot", out_valid, ev);
    if (ev != 0) begin
      tag = ef != 0 ? "R3 code" : (ee != 0 ? "R4 code" : "R1/R8 code");
      check(out_code == ec[8:0], tag, out_code, ec);
      check({out_empty, out_full} == {ee[0], ef[0]}, "R5 flags {empty,full}",
            {out_empty, out_full}, {ee[0], ef[0]});
    end
  endtask

  task automatic tick(input bit v, input logic [N-1:0] vec);
    int c, e, f;
    @(negedge clk);
    compare();
    in_valid = v;
    in_therm = vec;
    expect_of(vec, c, e, f);
    q_v.push_back(v); q_c.push_back(c); q_e.push_back(e); q_f.push_back(f);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) begin q_v.push_back(0); q_c.push_back(0); q_e.push_back(0); q_f.push_back(0); end
    // R7: nothing valid before the first valid input
    tick(0, '1);
    tick(0, '0);
    // R1/R3/R4 sweep of clean thermometers, idle slots for R6
    for (int k = 0; k <= N; k++) begin
      tick(1, therm(k));
      if (k % 7 == 3) tick(0, therm(k));
    end
    // R8 corners: lowest zero at 0 with ones above, single zero high up
    tick(1, ~{{(N-1){1'b0}}, 1'b1});
    tick(1, ~({{(N-1){1'b0}}, 1'b1} << 300));
    tick(1, ~({{(N-1){1'b0}}, 1'b1} << 511));
    // R8 random bubbled vectors with a chosen lowest zero
    for (int n = 0; n < 300; n++) begin
      int p;
      for (int w = 0; w < N / 32; w++) r[w*32 +: 32] = $urandom;
      p = $urandom % N;
      for (int i = 0; i < p; i++) r[i] = 1'b1;
      r[p] = 1'b0;
      tick((n % 5) != 4, r);
    end
    repeat (4) tick(0, '0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule